// File: doc/BRIEF.md
# Serial-Input Cascadable Parity Generator

This block listens to an idle-high asynchronous serial line, captures one byte per start edge and reports the even and odd parity of that byte. A falling edge on the line begins a reception. A divider derived from the clock frequency and the bit rate then samples eight data bits at their centres, least significant bit first, and shifts them into a parallel register.

When the eighth bit has been sampled, the byte is placed on the parallel output. The eight bits are XOR-reduced and combined with a cascade input, so that a chain of such blocks can build parity over a wider word: each stage passes its even output to the next stage's cascade input. Each of the two parity outputs has its own enable. A one-cycle strobe marks every new result. Stop bits, framing errors, oversampling and noise filtering are outside the block's job.

Top module: `serial_parity_rx`

## Requirements
- R1: While the serial line stays high no reception starts and `done_o` stays low. A high-to-low transition on the line, seen through a two-flop synchronizer, starts a reception.
- R2: One bit period is BIT_CYC = round(CLK_HZ / BAUD) clock cycles. The first data bit is sampled 1.5 bit periods after the start is detected, and each later bit one bit period after the one before it.
- R3: Exactly 8 data bits are captured per reception. The first bit received lands in `data_o[0]` and the last in `data_o[7]`.
- R4: The receive window ends on the eighth sample, 8.5 bit periods after the start. The start detector re-arms at that point, so a byte may follow after a single high stop bit.
- R5: Falling edges on the line during the receive window are ignored. They neither restart nor lengthen the reception.
- R6: `done_o` is a one-cycle pulse, two cycles after the last sample. `data_o`, the even result and the odd result change only on the cycle `done_o` goes high, and they hold their values until the next byte completes.
- R7: The even result is the XOR of the eight data bits with `cascade_in`, where `cascade_in` is sampled when the byte completes. `even_o` = `even_en` AND that result.
- R8: The odd result is the complement (XNOR) of the even result. `odd_o` = `odd_en` AND that result.
- R9: Both enables act combinationally on the stored results. A low enable forces its output low at once, and raising it again shows the stored value without a new byte.
- R10: After a synchronous active-low reset, `data_o`, `even_o`, `odd_o` and `done_o` are all 0, even with both enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| serial_in | input | 1 | Asynchronous serial data, idle high |
| cascade_in | input | 1 | Ninth parity bit from a preceding stage |
| even_en | input | 1 | Enable for the even output |
| odd_en | input | 1 | Enable for the odd output |
| data_o | output | DATA_W | Last completed byte |
| even_o | output | 1 | Gated even parity (XOR) |
| odd_o | output | 1 | Gated odd parity (XNOR) |
| done_o | output | 1 | One-cycle strobe for a new result |

## Verification
Most internal faults show at the ports within one byte time. A wrong bit index or a wrong phase in the divider shifts bits, and the next `done_o` then carries the wrong byte and parity. A start detector that stays armed during the window lets a data-bit edge restart the reception, which either delays `done_o` past its expected cycle or shuffles the byte. Faults in the output register or in enable gating show either as a value that changes mid-byte, or as a wrong level within one cycle of toggling an enable. The scoreboard checks every byte with `cascade_in` at both levels and under all four enable combinations, and it also runs a back-to-back pair with a single stop bit.

// File: rtl/spr_pkg.sv
// Package: shared types and helpers for the serial parity receiver.
// Assumes: integer clock and bit-rate values in hertz.
package spr_pkg;

    // Receive sequencer state.
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_t;

    // Rounded number of clock cycles per serial bit.
    function automatic int unsigned cycles_per_bit(input int unsigned clk_hz,
                                                   input int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/spr_edge_detect.sv
// Module: synchronizes the asynchronous serial line and flags a falling edge.
// Assumes: line idles high; arm is low while a reception is in progress, so
// edges seen then are dropped.
module spr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic arm,
    output logic start
);
    logic s1_q, s2_q, s3_q;

    // Two-flop synchronizer plus one history flop, reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= line_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Falling edge on the synchronized line, honoured only when armed.
    always_comb start = arm & s3_q & ~s2_q;

endmodule

// File: rtl/spr_bit_timer.sv
// Module: receive sequencer. It waits 1.5 bit periods after a start, then
// raises a sample strobe once per bit period for NBITS bits, and ends the
// window on the last strobe.
// Assumes: HALF_CYC >= 1, BIT_CYC >= 2.
module spr_bit_timer #(
    parameter int unsigned BIT_CYC  = 16,
    parameter int unsigned HALF_CYC = 8,
    parameter int unsigned NBITS    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic sample_stb,
    output logic last_stb
);
    import spr_pkg::*;

    localparam int unsigned FIRST_WAIT = BIT_CYC + HALF_CYC;
    localparam int unsigned CW         = $clog2(FIRST_WAIT + 1);
    localparam int unsigned IW         = $clog2(NBITS + 1);
    localparam int unsigned WIN_CYC    = NBITS * BIT_CYC + HALF_CYC;
    localparam int unsigned WW         = $clog2(WIN_CYC + 2);

    rx_state_t      state_q;
    logic [CW-1:0]  cnt_q;
    logic [IW-1:0]  idx_q;

    // Strobes decoded from the phase counter and the bit index.
    always_comb begin
        sample_stb = (state_q == RX_RECV) && (cnt_q == CW'(0));
        last_stb   = sample_stb && (idx_q == IW'(NBITS - 1));
        busy       = (state_q == RX_RECV);
    end

    // Phase counter, bit index and window state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else if (state_q == RX_IDLE) begin
            if (start) begin
                state_q <= RX_RECV;
                cnt_q   <= CW'(FIRST_WAIT - 1);
                idx_q   <= '0;
            end
        end else if (cnt_q == CW'(0)) begin
            cnt_q <= CW'(BIT_CYC - 1);
            idx_q <= idx_q + IW'(1);
            if (idx_q == IW'(NBITS - 1)) begin
                state_q <= RX_IDLE;
            end
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Window-length counter kept for the window checks below.
    logic [WW-1:0] win_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  win_q <= '0;
        else if (state_q == RX_IDLE) win_q <= '0;
        else                         win_q <= win_q + WW'(1);
    end

    assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx_q < IW'(NBITS)));

    // R4 and R5: a restart inside the window would stretch it past WIN_CYC.
    assert_window_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (win_q == WW'(WIN_CYC)));

    assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (win_q < WW'(WIN_CYC)));

endmodule

// File: rtl/spr_shift_reg.sv
// Module: serial-to-parallel register, shifting in LSB first on each strobe.
// Assumes: bit_in is the synchronized line, stable around the strobe.
module spr_shift_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] bits
);
    // New bit enters at the top; after W shifts the first bit sits at [0].
    always_ff @(posedge clk) begin
        if (!rst_n)        bits <= '0;
        else if (shift_en) bits <= {bit_in, bits[W-1:1]};
    end
endmodule

// File: rtl/spr_parity_core.sv
// Module: XOR-reduces the captured byte, folds in the cascade bit and
// registers data, even and odd results on a capture pulse.
// Assumes: capture is a single-cycle pulse after the byte is complete.
module spr_parity_core #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] bits,
    input  logic         cas,
    output logic [W-1:0] data_q,
    output logic         even_q,
    output logic         odd_q
);
    logic [W:0] chain;

    // XOR chain over the data bits, seeded with the cascade bit.
    assign chain[0] = cas;
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ bits[i];
    end

    // Result registers, loaded only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            even_q <= 1'b0;
            odd_q  <= 1'b0;
        end else if (capture) begin
            data_q <= bits;
            even_q <= chain[W];
            odd_q  <= ~chain[W];
        end
    end

    assert_odd_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(capture) |-> (even_q != odd_q));

endmodule

// File: rtl/serial_parity_rx.sv
// Module: top level. It starts on a falling serial edge, samples DATA_W bits
// at their centres, then publishes the byte and the enabled even/odd parity
// together with a one-cycle done strobe.
// Assumes: serial_in is idle high; cascade_in is stable when a byte completes.
module serial_parity_rx #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned BAUD   = 9600,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serial_in,
    input  logic              cascade_in,
    input  logic              even_en,
    input  logic              odd_en,
    output logic [DATA_W-1:0] data_o,
    output logic              even_o,
    output logic              odd_o,
    output logic              done_o
);
    localparam int unsigned BIT_CYC  = spr_pkg::cycles_per_bit(CLK_HZ, BAUD);
    localparam int unsigned HALF_CYC = BIT_CYC / 2;

    logic start, busy, sample_stb, last_stb;
    logic line_s1, line_s2;
    logic cap_q, done_q;
    logic [DATA_W-1:0] bits;
    logic even_q, odd_q;

    spr_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (serial_in),
        .arm     (~busy),
        .start   (start)
    );

    spr_bit_timer #(
        .BIT_CYC  (BIT_CYC),
        .HALF_CYC (HALF_CYC),
        .NBITS    (DATA_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .busy       (busy),
        .sample_stb (sample_stb),
        .last_stb   (last_stb)
    );

    // Separate synchronizer for the data path (kept away from the edge logic).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_s1 <= 1'b1;
            line_s2 <= 1'b1;
        end else begin
            line_s1 <= serial_in;
            line_s2 <= line_s1;
        end
    end

    spr_shift_reg #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_stb),
        .bit_in   (line_s2),
        .bits     (bits)
    );

    // Capture one cycle after the last sample, then raise done with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cap_q  <= last_stb;
            done_q <= cap_q;
        end
    end

    spr_parity_core #(.W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_q),
        .bits    (bits),
        .cas     (cascade_in),
        .data_q  (data_o),
        .even_q  (even_q),
        .odd_q   (odd_q)
    );

    // Enable gating, combinational on the stored results.
    always_comb begin
        even_o = even_en & even_q;
        odd_o  = odd_en & odd_q;
        done_o = done_q;
    end

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> done_o);

    assert_done_after_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

endmodule

// File: tb/serial_parity_rx_test.sv
// Bench: a scoreboard. The driver task queues the expected byte and cascade
// bit, then bit-bangs the line; the monitor pops an item on each done pulse.
module serial_parity_rx_test;
    localparam int unsigned BITP = 16;   // 1_600_000 / 100_000

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serial_in = 1'b1;
    logic cascade_in = 1'b0;
    logic even_en = 1'b0;
    logic odd_en = 1'b0;
    logic [7:0] data_o;
    logic even_o, odd_o, done_o;

    int checks = 0;
    int fails = 0;
    int dones = 0;
    bit finished = 1'b0;
    logic [8:0] expq[$];

    always #5 clk = ~clk;

    serial_parity_rx #(.CLK_HZ(1_600_000), .BAUD(100_000), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .cascade_in(cascade_in),
        .even_en(even_en), .odd_en(odd_en), .data_o(data_o), .even_o(even_o),
        .odd_o(odd_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one frame: start bit, 8 data bits LSB first, stop bits.
    task automatic send_byte(input logic [7:0] b, input logic cas, input int stops);
        logic [7:0] prev;
        prev = data_o;
        cascade_in = cas;
        expq.push_back({cas, b});
        @(posedge clk); #1 serial_in = 1'b0;
        repeat (BITP) @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            #1 serial_in = b[i];
            repeat (BITP) @(posedge clk);
            if (i == 3) check(data_o == prev, "R6 hold mid-byte", data_o, prev);
        end
        #1 serial_in = 1'b1;
        repeat (stops * BITP) @(posedge clk);
    endtask

    // Monitor: compare each completed byte with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            logic [8:0] e;
            logic ev;
            dones++;
            if (expq.size() == 0) begin
                check(1'b0, "R1 unexpected done", 1, 0);
            end else begin
                e = expq.pop_front();
                ev = ^e[7:0] ^ e[8];
                check(data_o == e[7:0], "R3 data", data_o, e[7:0]);
                check(even_o == (even_en & ev), "R7 even", even_o, even_en & ev);
                check(odd_o == (odd_en & ~ev), "R8 odd", odd_o, odd_en & ~ev);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] last;
        logic ev;
        even_en = 1'b1;
        odd_en = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(data_o == 8'h00 && !done_o, "R10 reset data/done", data_o, 0);
        check(!even_o && !odd_o, "R10 reset parity", {even_o, odd_o}, 0);

        // R1: idle line produces nothing.
        repeat (200) @(posedge clk);
        check(dones == 0, "R1 idle no done", dones, 0);

        // Corner bytes; 8'hAA and 8'h55 put falling edges inside the window (R5).
        send_byte(8'h00, 1'b0, 2);
        send_byte(8'hFF, 1'b0, 2);
        send_byte(8'hAA, 1'b1, 2);
        send_byte(8'h55, 1'b0, 2);
        send_byte(8'h01, 1'b1, 2);
        send_byte(8'h80, 1'b0, 2);

        // Sweep bytes, cascade levels and all enable combinations (R2, R7, R8, R9).
        for (int i = 0; i < 24; i++) begin
            even_en = i[2];
            odd_en  = i[3];
            send_byte(8'(i * 37 + 5), i[0], 2);
        end

        // R4: back-to-back frames with a single stop bit.
        even_en = 1'b1;
        odd_en = 1'b1;
        send_byte(8'hC3, 1'b0, 1);
        send_byte(8'h3C, 1'b1, 1);
        send_byte(8'h96, 1'b1, 2);

        // R9: enables act immediately on stored results (last byte 0x96, cas 1 -> even 1).
        last = 8'h96;
        ev = ^last ^ 1'b1;
        @(negedge clk);
        even_en = 1'b0; odd_en = 1'b0; #1;
        check(!even_o && !odd_o, "R9 enables low", {even_o, odd_o}, 0);
        even_en = 1'b1; #1;
        check(even_o == ev, "R9 even re-enabled", even_o, ev);
        odd_en = 1'b1; even_en = 1'b0; #1;
        check(odd_o == ~ev && !even_o, "R9 odd re-enabled", {even_o, odd_o}, {1'b0, ~ev});
        check(data_o == last, "R6 data held", data_o, last);

        repeat (40) @(posedge clk);
        check(expq.size() == 0, "R6 all bytes completed", expq.size(), 0);
        check(dones == 33, "R3 done count", dones, 33);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule